// File: doc/BRIEF.md
# Instruction Fetch and Length Decoder

This block walks a stream of 16-bit instruction words held in a program memory that is reached through a simple request/valid port. It keeps a byte-addressed program counter that is always even. For each instruction it fetches the leading word and sorts it into one of three formats: jump, one-operand or two-operand. It pulls out the opcode, the byte/word flag, the registers and their addressing modes. It then fetches however many extension words the operand modes call for, which is zero, one or two.

When the last word of an instruction has arrived, the block emits a decoded record for one cycle. The record carries every extracted field. It also carries the operand kind that results from combining each mode with its register number. This is how constants, symbolic, absolute and immediate operands are told apart from plain register, indexed and indirect ones. Operand values come already resolved: a constant value, a literal, an absolute address, an index, or a symbolic address that has already been rebased on the program counter. For a jump, the record holds the computed branch target. Leading words that match no format are flagged as illegal and take up one word. The block does not execute operands, read data memory or evaluate jump conditions.

Top module: `fetch_len_decode`

## Requirements
- R1: No fetch is issued while reset is held. The first fetch after reset reads address RESET_PC. Every fetch address is even. Each fetched word, extension words included, advances the next fetch address by 2, so the next instruction starts straight after the last extension word of the previous one.
- R2: Format codes on dec_fmt are 0 for jump, 1 for one-operand, 2 for two-operand and 3 for illegal. Leading bits 001 select jump. Top four bits from 0100 to 1111 select two-operand. Top six bits 000100 select one-operand.
- R3: For two-operand words, dec_op is bits 15:12 and dec_byte is bit 6. The source register is bits 11:8 with mode bits 5:4. The destination register is bits 3:0 with mode bit 7. For one-operand words, dec_op is bits 9:7 and dec_byte is bit 6. The single operand is reported in the source fields, decoded from bits 5:4 and register bits 3:0, and the destination fields are zero.
- R4: Source kinds on dec_src_kind are 0 register, 1 indexed, 2 indirect, 3 indirect with autoincrement, 4 constant, 5 symbolic, 6 absolute and 7 immediate. For a general register, source mode bits 00/01/10/11 give kinds 0/1/2/3. Only kind 1 fetches an extension word, and dec_src_val then holds that index.
- R5: With register 3 as source, modes 00/01/10/11 give kind 4 with values 0, 1, 2 and 0xFFFF. With register 2 as source, mode 10 gives kind 4 with value 4, mode 11 gives kind 4 with value 8, and mode 00 gives kind 0. None of these fetches an extension word.
- R6: With register 0 as source, mode 01 gives kind 5, and dec_src_val is the index word plus the address that word was read from. Mode 11 gives kind 7, with the literal word in dec_src_val. Mode 10 gives kind 2. With register 2 as source, mode 01 gives kind 6, with the address word in dec_src_val.
- R7: A destination mode bit of 0 gives kind 0 with no extension word. A mode bit of 1 fetches one word. With register 0 this gives kind 5, with value equal to the word plus its address. With register 2 it gives kind 6. Any other register, register 3 included, gives kind 1.
- R8: The source extension word is fetched before the destination extension word. dec_len equals 1 plus the number of extension words.
- R9: A jump uses no extension word. dec_op is bits 12:10. dec_target equals the address of the jump word plus 2 plus twice the sign-extended bits 9:0.
- R10: A word whose top four bits are 0000, whose top six bits are 000101, 000110 or 000111, or that is one-operand with bits 9:7 equal to 111, raises dec_illegal with format 3 and dec_len 1. All other record fields are zero except dec_pc.
- R11: mem_req is high for exactly one cycle per word, and only one fetch is outstanding at a time. The block waits any number of cycles for mem_rvalid. dec_valid pulses for one cycle, in the cycle after the last word of the instruction returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Word fetch request, one cycle |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_rvalid | input | 1 | Fetched word is present on mem_rdata |
| mem_rdata | input | 16 | Fetched word |
| dec_valid | output | 1 | Decoded record strobe |
| dec_pc | output | 16 | Address of the leading word |
| dec_fmt | output | 2 | Format code |
| dec_op | output | 4 | Opcode field |
| dec_byte | output | 1 | Byte operation flag |
| dec_src_reg | output | 4 | Source (or single operand) register |
| dec_src_kind | output | 3 | Source operand kind |
| dec_src_val | output | 16 | Resolved source constant, literal, index or address |
| dec_dst_reg | output | 4 | Destination register |
| dec_dst_kind | output | 3 | Destination operand kind |
| dec_dst_val | output | 16 | Resolved destination index or address |
| dec_target | output | 16 | Jump target address |
| dec_illegal | output | 1 | Unused encoding seen |
| dec_len | output | 2 | Instruction length in words |

## Verification
A program counter that drifts is visible on the next mem_addr, within one fetch. Because the decoder stays framed on the stream, a wrong extension-word count shifts every later instruction. The next record then shows a wrong dec_pc, and extension words start being read as leading words. Mis-sorting a mode/register pair gives a wrong kind or value, and often a wrong dec_len, in the very record that contains it. Fetch latency varies from word to word, so a decoder that captures data without waiting for mem_rvalid records stale words.

// File: rtl/fld_pkg.sv
package fld_pkg;
    localparam int WORD_W = 16;
    localparam int REG_W  = 4;
    localparam int OP_W   = 4;
    localparam int LEN_W  = 2;
    localparam int OFF_W  = 10;
    localparam int KIND_W = 3;

    typedef enum logic [1:0] {
        FMT_JUMP = 2'd0,
        FMT_ONE  = 2'd1,
        FMT_TWO  = 2'd2,
        FMT_BAD  = 2'd3
    } fmt_e;

    typedef enum logic [KIND_W-1:0] {
        K_REG   = 3'd0,
        K_IDX   = 3'd1,
        K_IND   = 3'd2,
        K_INC   = 3'd3,
        K_CONST = 3'd4,
        K_SYM   = 3'd5,
        K_ABS   = 3'd6,
        K_IMM   = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        STG_IDLE = 2'd0,
        STG_OP   = 2'd1,
        STG_SRC  = 2'd2,
        STG_DST  = 2'd3
    } stage_e;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        fmt_e              fmt;
        logic [OP_W-1:0]   op;
        logic              byte_op;
        logic [REG_W-1:0]  src_reg;
        kind_e             src_kind;
        logic [WORD_W-1:0] src_val;
        logic [REG_W-1:0]  dst_reg;
        kind_e             dst_kind;
        logic [WORD_W-1:0] dst_val;
        logic [WORD_W-1:0] target;
        logic              illegal;
        logic [LEN_W-1:0]  len;
    } rec_t;

    typedef struct packed {
        stage_e            stage;
        logic              waiting;
        logic [WORD_W-1:0] pc;
        logic              need_dst;
        logic              out_valid;
        rec_t              rec;
    } state_t;
endpackage

// File: rtl/fld_classify.sv
module fld_classify
    import fld_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fmt_e              fmt,
    output logic [OP_W-1:0]   op,
    output logic              byte_op,
    output logic [REG_W-1:0]  src_reg,
    output logic [1:0]        src_mode,
    output logic              has_src,
    output logic [REG_W-1:0]  dst_reg,
    output logic              dst_mode,
    output logic              has_dst,
    output logic [OFF_W-1:0]  jmp_off
);
    localparam logic [2:0] JUMP_TAG   = 3'b001;
    localparam logic [5:0] ONE_TAG    = 6'b000100;
    localparam logic [2:0] ONE_UNUSED = 3'b111;

    always_comb begin
        fmt      = FMT_BAD;
        op       = '0;
        byte_op  = 1'b0;
        src_reg  = '0;
        src_mode = 2'b00;
        has_src  = 1'b0;
        dst_reg  = '0;
        dst_mode = 1'b0;
        has_dst  = 1'b0;
        jmp_off  = '0;
        if (word[15:13] == JUMP_TAG) begin
            fmt     = FMT_JUMP;
            op      = {1'b0, word[12:10]};
            jmp_off = word[OFF_W-1:0];
        end else if (word[15:14] != 2'b00) begin
            fmt      = FMT_TWO;
            op       = word[15:12];
            byte_op  = word[6];
            src_reg  = word[11:8];
            src_mode = word[5:4];
            has_src  = 1'b1;
            dst_reg  = word[3:0];
            dst_mode = word[7];
            has_dst  = 1'b1;
        end else if (word[15:10] == ONE_TAG && word[9:7] != ONE_UNUSED) begin
            fmt      = FMT_ONE;
            op       = {1'b0, word[9:7]};
            byte_op  = word[6];
            src_reg  = word[3:0];
            src_mode = word[5:4];
            has_src  = 1'b1;
        end
    end
endmodule

// File: rtl/fld_src_mode.sv
module fld_src_mode
    import fld_pkg::*;
#(
    parameter int PC_NUM = 0,
    parameter int SR_NUM = 2,
    parameter int CG_NUM = 3
) (
    input  logic [REG_W-1:0]  reg_num,
    input  logic [1:0]        mode,
    output kind_e             kind,
    output logic [WORD_W-1:0] cval,
    output logic              ext
);
    always_comb begin
        kind = K_REG;
        cval = '0;
        ext  = 1'b0;
        if (reg_num == REG_W'(CG_NUM)) begin
            kind = K_CONST;
            unique case (mode)
                2'b00: cval = WORD_W'(0);
                2'b01: cval = WORD_W'(1);
                2'b10: cval = WORD_W'(2);
                default: cval = '1;
            endcase
        end else if (reg_num == REG_W'(SR_NUM)) begin
            unique case (mode)
                2'b00: kind = K_REG;
                2'b01: begin kind = K_ABS; ext = 1'b1; end
                2'b10: begin kind = K_CONST; cval = WORD_W'(4); end
                default: begin kind = K_CONST; cval = WORD_W'(8); end
            endcase
        end else if (reg_num == REG_W'(PC_NUM)) begin
            unique case (mode)
                2'b00: kind = K_REG;
                2'b01: begin kind = K_SYM; ext = 1'b1; end
                2'b10: kind = K_IND;
                default: begin kind = K_IMM; ext = 1'b1; end
            endcase
        end else begin
            unique case (mode)
                2'b00: kind = K_REG;
                2'b01: begin kind = K_IDX; ext = 1'b1; end
                2'b10: kind = K_IND;
                default: kind = K_INC;
            endcase
        end
    end
endmodule

// File: rtl/fld_dst_mode.sv
module fld_dst_mode
    import fld_pkg::*;
#(
    parameter int PC_NUM = 0,
    parameter int SR_NUM = 2
) (
    input  logic [REG_W-1:0] reg_num,
    input  logic             mode,
    output kind_e            kind,
    output logic             ext
);
    always_comb begin
        ext = mode;
        if (!mode)                            kind = K_REG;
        else if (reg_num == REG_W'(PC_NUM))   kind = K_SYM;
        else if (reg_num == REG_W'(SR_NUM))   kind = K_ABS;
        else                                  kind = K_IDX;
    end
endmodule

// File: rtl/fetch_len_decode.sv
module fetch_len_decode
    import fld_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [15:0] mem_rdata,
    output logic        dec_valid,
    output logic [15:0] dec_pc,
    output logic [1:0]  dec_fmt,
    output logic [3:0]  dec_op,
    output logic        dec_byte,
    output logic [3:0]  dec_src_reg,
    output logic [2:0]  dec_src_kind,
    output logic [15:0] dec_src_val,
    output logic [3:0]  dec_dst_reg,
    output logic [2:0]  dec_dst_kind,
    output logic [15:0] dec_dst_val,
    output logic [15:0] dec_target,
    output logic        dec_illegal,
    output logic [1:0]  dec_len
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(2);
    localparam int SEXT_W = WORD_W - OFF_W - 1;

    state_t q, d;

    fmt_e              c_fmt;
    logic [OP_W-1:0]   c_op;
    logic              c_byte;
    logic [REG_W-1:0]  c_sreg, c_dreg;
    logic [1:0]        c_smode;
    logic              c_dmode, c_has_src, c_has_dst;
    logic [OFF_W-1:0]  c_off;
    kind_e             s_kind, dd_kind;
    logic [WORD_W-1:0] s_cval;
    logic              s_ext, dd_ext;

    fld_classify u_cls (
        .word(mem_rdata), .fmt(c_fmt), .op(c_op), .byte_op(c_byte),
        .src_reg(c_sreg), .src_mode(c_smode), .has_src(c_has_src),
        .dst_reg(c_dreg), .dst_mode(c_dmode), .has_dst(c_has_dst),
        .jmp_off(c_off)
    );

    fld_src_mode u_src (
        .reg_num(c_sreg), .mode(c_smode), .kind(s_kind), .cval(s_cval), .ext(s_ext)
    );

    fld_dst_mode u_dst (
        .reg_num(c_dreg), .mode(c_dmode), .kind(dd_kind), .ext(dd_ext)
    );

    always_comb begin
        logic need_src, need_dst;
        d = q;
        d.out_valid = 1'b0;
        need_src = c_has_src && s_ext;
        need_dst = c_has_dst && dd_ext;
        if (q.stage == STG_IDLE) begin
            d.stage = STG_OP;
        end else if (!q.waiting) begin
            d.waiting = 1'b1;
        end else if (mem_rvalid) begin
            d.waiting = 1'b0;
            d.pc      = q.pc + STEP;
            unique case (q.stage)
                STG_OP: begin
                    d.rec          = '0;
                    d.rec.pc       = q.pc;
                    d.rec.fmt      = c_fmt;
                    d.rec.op       = c_op;
                    d.rec.byte_op  = c_byte;
                    d.rec.src_reg  = c_sreg;
                    d.rec.src_kind = c_has_src ? s_kind : K_REG;
                    d.rec.src_val  = (c_has_src && s_kind == K_CONST) ? s_cval : '0;
                    d.rec.dst_reg  = c_dreg;
                    d.rec.dst_kind = c_has_dst ? dd_kind : K_REG;
                    d.rec.illegal  = (c_fmt == FMT_BAD);
                    d.rec.len      = LEN_W'(1);
                    if (c_fmt == FMT_JUMP)
                        d.rec.target = q.pc + STEP + {{SEXT_W{c_off[OFF_W-1]}}, c_off, 1'b0};
                    d.need_dst = need_dst;
                    if (need_src)      d.stage = STG_SRC;
                    else if (need_dst) d.stage = STG_DST;
                    else               d.out_valid = 1'b1;
                end
                STG_SRC: begin
                    d.rec.src_val = (q.rec.src_kind == K_SYM) ? mem_rdata + q.pc : mem_rdata;
                    d.rec.len     = q.rec.len + LEN_W'(1);
                    if (q.need_dst) begin
                        d.stage = STG_DST;
                    end else begin
                        d.stage     = STG_OP;
                        d.out_valid = 1'b1;
                    end
                end
                default: begin
                    d.rec.dst_val = (q.rec.dst_kind == K_SYM) ? mem_rdata + q.pc : mem_rdata;
                    d.rec.len     = q.rec.len + LEN_W'(1);
                    d.stage       = STG_OP;
                    d.out_valid   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.stage    <= STG_IDLE;
            q.pc       <= {RESET_PC[15:1], 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mem_req      = (q.stage != STG_IDLE) && !q.waiting;
    assign mem_addr     = q.pc;
    assign dec_valid    = q.out_valid;
    assign dec_pc       = q.rec.pc;
    assign dec_fmt      = q.rec.fmt;
    assign dec_op       = q.rec.op;
    assign dec_byte     = q.rec.byte_op;
    assign dec_src_reg  = q.rec.src_reg;
    assign dec_src_kind = q.rec.src_kind;
    assign dec_src_val  = q.rec.src_val;
    assign dec_dst_reg  = q.rec.dst_reg;
    assign dec_dst_kind = q.rec.dst_kind;
    assign dec_dst_val  = q.rec.dst_val;
    assign dec_target   = q.rec.target;
    assign dec_illegal  = q.rec.illegal;
    assign dec_len      = q.rec.len;

    // Address history kept only for the fetch-order properties below
    logic [15:0] last_addr_q;
    logic        seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr_q <= '0;
            seen_q      <= 1'b0;
        end else if (mem_req) begin
            last_addr_q <= mem_addr;
            seen_q      <= 1'b1;
        end
    end

    assert_addr_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[0] == 1'b0));

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && seen_q) |-> (mem_addr == last_addr_q + 16'd2));

    assert_first_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !seen_q) |-> (mem_addr == {RESET_PC[15:1], 1'b0}));

    assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_jump_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_fmt == 2'd0) |-> (dec_len == 2'd1));

    assert_illegal_rec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_illegal) |-> (dec_len == 2'd1 && dec_fmt == 2'd3));

    assert_const_no_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_fmt != 2'd3 && dec_src_kind == 3'd4 && dec_dst_kind == 3'd0)
        |-> (dec_len == 2'd1));

    assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_len != 2'd0));
endmodule

// File: tb/fetch_len_decode_tb_top.sv
module fetch_len_decode_tb_top;
    localparam logic [15:0] BASE = 16'h0100;
    localparam int MEM_N = 128;

    typedef struct packed {
        logic [15:0] pc;
        logic [1:0]  fmt;
        logic [3:0]  op;
        logic        b;
        logic [3:0]  sreg;
        logic [2:0]  sk;
        logic [15:0] sv;
        logic [3:0]  dreg;
        logic [2:0]  dk;
        logic [15:0] dv;
        logic [15:0] jt;
        logic        ill;
        logic [1:0]  len;
    } rec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_req, mem_rvalid;
    logic [15:0] mem_addr, mem_rdata;
    logic dec_valid, dec_byte, dec_illegal;
    logic [15:0] dec_pc, dec_src_val, dec_dst_val, dec_target;
    logic [1:0] dec_fmt, dec_len;
    logic [3:0] dec_op, dec_src_reg, dec_dst_reg;
    logic [2:0] dec_src_kind, dec_dst_kind;

    always #2.5 clk = ~clk;

    fetch_len_decode #(.RESET_PC(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_fmt(dec_fmt), .dec_op(dec_op),
        .dec_byte(dec_byte), .dec_src_reg(dec_src_reg), .dec_src_kind(dec_src_kind),
        .dec_src_val(dec_src_val), .dec_dst_reg(dec_dst_reg), .dec_dst_kind(dec_dst_kind),
        .dec_dst_val(dec_dst_val), .dec_target(dec_target), .dec_illegal(dec_illegal),
        .dec_len(dec_len)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [MEM_N];
    logic [15:0] wp = BASE;
    rec_t  exp_q [$];
    string tag_q [$];

    // Program memory: one outstanding word, latency cycling 1..4 cycles
    logic       busy;
    int         cnt, nreq;
    logic [15:0] addr_l;
    function automatic int idx(input logic [15:0] a);
        return int'(((a - BASE) >> 1) & 16'(MEM_N - 1));
    endfunction
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0; busy <= 1'b0; cnt <= 0; nreq <= 0;
            mem_rdata <= '0; addr_l <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req) begin
                busy <= 1'b1; cnt <= nreq % 4; nreq <= nreq + 1; addr_l <= mem_addr;
            end else if (busy) begin
                if (cnt == 0) begin
                    mem_rvalid <= 1'b1; mem_rdata <= mem[idx(addr_l)]; busy <= 1'b0;
                end else cnt <= cnt - 1;
            end
        end
    end

    function automatic rec_t mk(input logic [1:0] fmt, input logic [3:0] op, input logic b,
                                input logic [3:0] sreg, input logic [2:0] sk, input logic [15:0] sv,
                                input logic [3:0] dreg, input logic [2:0] dk, input logic [15:0] dv,
                                input logic ill);
        rec_t r = '0;
        r.fmt = fmt; r.op = op; r.b = b; r.sreg = sreg; r.sk = sk; r.sv = sv;
        r.dreg = dreg; r.dk = dk; r.dv = dv; r.ill = ill;
        return r;
    endfunction

    // Driver: place words in memory and queue the record the requirements predict
    task automatic put(input logic [15:0] w0, input logic [15:0] x1, input logic [15:0] x2,
                       input int nx, input rec_t e, input string tag);
        logic [15:0] dw;
        mem[idx(wp)] = w0;
        if (nx > 0) mem[idx(wp + 16'd2)] = x1;
        if (nx > 1) mem[idx(wp + 16'd4)] = x2;
        e.pc  = wp;
        e.len = 2'(nx + 1);
        if (e.sk == 3'd5) e.sv = x1 + wp + 16'd2;
        dw = (nx == 2) ? x2 : x1;
        if (e.dk == 3'd5) e.dv = dw + wp + 16'(2 * nx);
        if (e.fmt == 2'd0) e.jt = wp + 16'd2 + {{5{w0[9]}}, w0[9:0], 1'b0};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        wp = wp + 16'(2 * (nx + 1));
    endtask

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = 16'h4304;
        put(16'h4506, 0, 0, 0, mk(2, 4, 0, 5, 0, 0, 6, 0, 0, 0), "R3 two-operand reg/reg");
        put(16'h54F7, 16'h0002, 0, 1, mk(2, 5, 1, 4, 3, 0, 7, 1, 16'h0002, 0), "R4 autoinc src byte, R7 indexed dst");
        put(16'h40B2, 16'h1234, 16'h0200, 2, mk(2, 4, 0, 0, 7, 16'h1234, 2, 6, 16'h0200, 0), "R8 immediate then absolute (R6 R7)");
        put(16'h9339, 0, 0, 0, mk(2, 9, 0, 3, 4, 16'hFFFF, 9, 0, 0, 0), "R5 r3 mode 11");
        put(16'hD23A, 0, 0, 0, mk(2, 13, 0, 2, 4, 16'h0008, 10, 0, 0, 0), "R5 r2 mode 11");
        put(16'hC22B, 0, 0, 0, mk(2, 12, 0, 2, 4, 16'h0004, 11, 0, 0, 0), "R5 r2 mode 10");
        put(16'hE31C, 0, 0, 0, mk(2, 14, 0, 3, 4, 16'h0001, 12, 0, 0, 0), "R5 r3 mode 01");
        put(16'hE304, 0, 0, 0, mk(2, 14, 0, 3, 4, 16'h0000, 4, 0, 0, 0), "R5 r3 mode 00");
        put(16'hE325, 0, 0, 0, mk(2, 14, 0, 3, 4, 16'h0002, 5, 0, 0, 0), "R5 r3 mode 10");
        put(16'h4090, 16'h0010, 16'h0020, 2, mk(2, 4, 0, 0, 5, 0, 0, 5, 0, 0), "R6 symbolic src, R7 symbolic dst, R8 order");
        put(16'h4218, 16'h0300, 0, 1, mk(2, 4, 0, 2, 6, 16'h0300, 8, 0, 0, 0), "R6 absolute src");
        put(16'h5516, 16'h0004, 0, 1, mk(2, 5, 0, 5, 1, 16'h0004, 6, 0, 0, 0), "R4 indexed src");
        put(16'h4728, 0, 0, 0, mk(2, 4, 0, 7, 2, 0, 8, 0, 0, 0), "R4 indirect src");
        put(16'h4028, 0, 0, 0, mk(2, 4, 0, 0, 2, 0, 8, 0, 0, 0), "R6 r0 mode 10 indirect");
        put(16'h4203, 0, 0, 0, mk(2, 4, 0, 2, 0, 0, 3, 0, 0, 0), "R5 r2 mode 00 register, R7 r3 dst reg");
        put(16'h1045, 0, 0, 0, mk(1, 0, 1, 5, 0, 0, 0, 0, 0, 0), "R3 one-operand byte reg");
        put(16'h1230, 16'h55AA, 0, 1, mk(1, 4, 0, 0, 7, 16'h55AA, 0, 0, 0, 0), "R3 one-operand immediate");
        put(16'h1292, 16'h0400, 0, 1, mk(1, 5, 0, 2, 6, 16'h0400, 0, 0, 0, 0), "R3 one-operand absolute");
        put(16'h1380, 0, 0, 0, mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 1), "R10 one-operand opcode 111");
        put(16'h0ABC, 0, 0, 0, mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 1), "R10 top bits 0000");
        put(16'h1800, 0, 0, 0, mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 1), "R10 top bits 000110");
        put(16'h3C03, 0, 0, 0, mk(0, 7, 0, 0, 0, 0, 0, 0, 0, 0), "R9 forward jump");
        put(16'h23FC, 0, 0, 0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R9 backward jump");
        put(16'h2E00, 0, 0, 0, mk(0, 3, 0, 0, 0, 0, 0, 0, 0, 0), "R9 most negative offset");
        put(16'h4483, 16'h0006, 0, 1, mk(2, 4, 0, 4, 0, 0, 3, 1, 16'h0006, 0), "R7 r3 dst indexed");
        put(16'h5990, 16'h0002, 16'h0100, 2, mk(2, 5, 0, 9, 1, 16'h0002, 0, 5, 0, 0), "R8 indexed src then symbolic dst");

        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0 && dec_valid == 1'b0, "R1 no fetch in reset",
            {mem_req, dec_valid}, 0);
        rst_n = 1'b1;
    end

    // Monitor: fetch addresses, handshake and decoded records
    logic [15:0] exp_addr = BASE;
    int cyc = 0;
    always @(negedge clk) begin
        rec_t a;
        rec_t e;
        string t;
        cyc++;
        if (rst_n && mem_req) begin
            chk(mem_addr == exp_addr, "R1 fetch address", mem_addr, exp_addr);
            chk(busy == 1'b0, "R11 single outstanding fetch", busy, 0);
            exp_addr = exp_addr + 16'd2;
        end
        if (rst_n && dec_valid && exp_q.size() > 0) begin
            a = '0;
            a.pc = dec_pc; a.fmt = dec_fmt; a.op = dec_op; a.b = dec_byte;
            a.sreg = dec_src_reg; a.sk = dec_src_kind; a.sv = dec_src_val;
            a.dreg = dec_dst_reg; a.dk = dec_dst_kind; a.dv = dec_dst_val;
            a.jt = dec_target; a.ill = dec_illegal; a.len = dec_len;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(a == e, t, 256'(a), 256'(e));
            if (exp_q.size() == 0) begin
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog: decoder stalled, %0d records outstanding", exp_q.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule